// File: doc/BRIEF.md
# General Purpose Event Enable and Status Logic

This block holds a 32-bit set of event status latches and a matching 32-bit enable register, paired bit for bit. Each event source pulses its status bit for one cycle and the bit stays set. Software clears it by writing a one to that position. An enabled, set status bit raises a system control interrupt (SCI), a wake request, or both. The choice depends on how that bit position is routed.

The bits sit in two power domains, and each domain has its own synchronous reset. The resume domain holds bits 31:16, 12 and 6:0. The RTC domain holds bits 13, 11 and 8. A power button override clears most enables, but bits 13 and 8 survive it. A platform hard reset clears the resume-domain enables and leaves the RTC-domain enables intact. Bit 13 is therefore cleared only by software or the RTC-domain reset. Bit 8 survives a hard reset and a full power loss of the resume domain.

Both registers are reached through one simple register port. A select line picks the register, and the read data is combinational.

Top module: `gpe_evt_ctrl`

## Requirements
- R1: After both domain resets have been applied, the status register, the enable register, `sci_o` and `wake_o` all read 0.
- R2: With `reg_sel`=1 a write loads the enable register, and the write is visible on `reg_rdata` from the following cycle. Bits 15, 14, 10, 9 and 7 are reserved: they read 0 in both registers and ignore writes and event pulses.
- R3: With `reg_sel`=0 a write clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value. A one-cycle pulse on `evt_pulse[i]` sets status bit i.
- R4: When an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `sci_o` is a register. One cycle after some status bit i is set with enable bit i also set, `sci_o` is 1. This holds for i in 31:16, 13, 11, 6 and 3:0, and no other bit drives `sci_o`.
- R6: `wake_o` is a register. One cycle after some status bit i is set with enable bit i also set, `wake_o` is 1. This holds for i in 31:16, 13, 12, 11, 8, 5 and 4, and no other bit drives `wake_o`.
- R7: `rst_resume` clears the enable and status bits of the resume domain (31:16, 12, 6:0). Bits 13, 11 and 8 keep their value.
- R8: `rst_rtc` clears the enable and status bits 13, 11 and 8 only. All resume-domain bits keep their value.
- R9: A `pbo_evt` cycle clears every enable bit except 13 and 8. It has priority over a write in the same cycle, and it leaves the status bits unchanged.
- R10: A `hard_rst` cycle clears the resume-domain enable bits and leaves enable bits 13, 11 and 8 and all status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_resume | input | 1 | Synchronous active-high reset of the resume domain |
| rst_rtc | input | 1 | Synchronous active-high reset of the RTC domain |
| pbo_evt | input | 1 | Power button override, one cycle |
| hard_rst | input | 1 | Platform hard reset request, one cycle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| evt_pulse | input | 32 | One-cycle event pulses, one per status bit |
| sci_o | output | 1 | Registered SCI request |
| wake_o | output | 1 | Registered wake request |

## Verification
The bench applies each reset and clearing input on its own, with every enable and status bit set beforehand. It then compares both registers against the masks each input is supposed to spare. A design that let the RTC reset leak into the resume domain, or let an override clear bit 13 or bit 8, shows up as a wrong read-back. The bench routes single bits one at a time to separate SCI-only, wake-only and dual-routed positions, and it samples the output one cycle early to catch a missing register stage. A same-cycle pulse and clear checks the set-over-clear priority, and writes of all ones check that the reserved bits stay zero.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

    localparam int GPE_W = 32;

    typedef logic [GPE_W-1:0] gpe_vec_t;

    typedef enum logic {
        SEL_STS = 1'b0,
        SEL_EN  = 1'b1
    } gpe_sel_e;

    // Bit classes; positions matter because status and enable pair by index.
    localparam gpe_vec_t RSVD_MASK   = 32'h0000_C680;
    localparam gpe_vec_t IMPL_MASK   = ~RSVD_MASK;
    localparam gpe_vec_t SCI_MASK    = 32'hFFFF_284F;
    localparam gpe_vec_t WAKE_MASK   = 32'hFFFF_3930;
    localparam gpe_vec_t RTC_MASK    = 32'h0000_2900;
    localparam gpe_vec_t RESUME_MASK = IMPL_MASK & ~RTC_MASK;
    localparam gpe_vec_t PBO_KEEP    = 32'h0000_2100;
    localparam gpe_vec_t PBO_CLR     = IMPL_MASK & ~PBO_KEEP;
    localparam gpe_vec_t HARD_CLR    = RESUME_MASK;

    typedef struct packed {
        logic impl;
        logic rtc;
        logic pbo_clr;
        logic hard_clr;
    } gpe_rule_t;

    function automatic gpe_rule_t gpe_rule(input int idx);
        gpe_rule_t r;
        r.impl     = IMPL_MASK[idx];
        r.rtc      = RTC_MASK[idx];
        r.pbo_clr  = PBO_CLR[idx];
        r.hard_clr = HARD_CLR[idx];
        return r;
    endfunction

endpackage

// File: rtl/gpe_status_bank.sv
module gpe_status_bank
    import gpe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_resume,
    input  logic     rst_rtc,
    input  logic     clr_wr,
    input  gpe_vec_t clr_data,
    input  gpe_vec_t pulse,
    output gpe_vec_t sts_q
);

    for (genvar i = 0; i < GPE_W; i++) begin : g_bit
        localparam gpe_rule_t RULE = gpe_rule(i);
        if (RULE.impl) begin : g_impl
            logic dom_rst;
            logic bit_q;
            assign dom_rst = RULE.rtc ? rst_rtc : rst_resume;
            always_ff @(posedge clk) begin
                if (dom_rst)
                    bit_q <= 1'b0;
                else if (pulse[i])
                    bit_q <= 1'b1;
                else if (clr_wr && clr_data[i])
                    bit_q <= 1'b0;
            end
            assign sts_q[i] = bit_q;
        end else begin : g_rsvd
            logic unused_in;
            assign unused_in = pulse[i] ^ clr_data[i];
            assign sts_q[i]  = 1'b0;
        end
    end

    // R3: a write of ones leaves those bits clear when no pulse competes
    a_r3_w1c_clears: assert property (@(posedge clk)
        disable iff (rst_resume || rst_rtc)
        (clr_wr && pulse == '0) |=> ((sts_q & $past(clr_data)) == '0));

    // R4: a pulse always lands, even against a same-cycle clear
    a_r4_set_wins: assert property (@(posedge clk)
        disable iff (rst_resume || rst_rtc)
        (pulse != '0) |=> ((sts_q & $past(pulse & IMPL_MASK)) == $past(pulse & IMPL_MASK)));

    // R2: reserved status bits never rise
    a_r2_sts_rsvd: assert property (@(posedge clk)
        disable iff (rst_resume || rst_rtc)
        (pulse != '0) |=> ((sts_q & RSVD_MASK) == '0));

endmodule

// File: rtl/gpe_enable_bank.sv
module gpe_enable_bank
    import gpe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_resume,
    input  logic     rst_rtc,
    input  logic     pbo_evt,
    input  logic     hard_rst,
    input  logic     en_wr,
    input  gpe_vec_t en_data,
    output gpe_vec_t en_q
);

    for (genvar i = 0; i < GPE_W; i++) begin : g_bit
        localparam gpe_rule_t RULE = gpe_rule(i);
        if (RULE.impl) begin : g_impl
            logic dom_rst;
            logic bit_q;
            assign dom_rst = RULE.rtc ? rst_rtc : rst_resume;
            always_ff @(posedge clk) begin
                if (dom_rst)
                    bit_q <= 1'b0;
                else if (pbo_evt && RULE.pbo_clr)
                    bit_q <= 1'b0;
                else if (hard_rst && RULE.hard_clr)
                    bit_q <= 1'b0;
                else if (en_wr)
                    bit_q <= en_data[i];
            end
            assign en_q[i] = bit_q;
        end else begin : g_rsvd
            logic unused_in;
            assign unused_in = en_data[i];
            assign en_q[i]   = 1'b0;
        end
    end

    // R9: override leaves only the two protected enables
    a_r9_pbo_clear: assert property (@(posedge clk)
        disable iff (rst_resume || rst_rtc)
        pbo_evt |=> ((en_q & PBO_CLR) == '0));

    // R10: hard reset empties the resume-domain enables
    a_r10_hard_clear: assert property (@(posedge clk)
        disable iff (rst_resume || rst_rtc)
        hard_rst |=> ((en_q & RESUME_MASK) == '0));

    // R10: RTC-domain enables ride through a hard reset
    a_r10_rtc_keep: assert property (@(posedge clk)
        disable iff (rst_resume || rst_rtc)
        (hard_rst && !pbo_evt && !en_wr) |=> ((en_q & RTC_MASK) == $past(en_q & RTC_MASK)));

    // R8: RTC reset leaves resume-domain enables alone
    a_r8_resume_keep: assert property (@(posedge clk)
        disable iff (rst_resume)
        (rst_rtc && !pbo_evt && !hard_rst && !en_wr)
        |=> ((en_q & RESUME_MASK) == $past(en_q & RESUME_MASK)));

endmodule

// File: rtl/gpe_route.sv
module gpe_route
    import gpe_pkg::*;
(
    input  logic     clk,
    input  logic     rst_any,
    input  gpe_vec_t sts_q,
    input  gpe_vec_t en_q,
    output logic     sci_q,
    output logic     wake_q
);

    gpe_vec_t armed;
    assign armed = sts_q & en_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            sci_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            sci_q  <= |(armed & SCI_MASK);
            wake_q <= |(armed & WAKE_MASK);
        end
    end

    // R5: nothing armed on an SCI position means no SCI next cycle
    a_r5_sci_quiet: assert property (@(posedge clk)
        disable iff (rst_any)
        ((armed & SCI_MASK) == '0) |=> !sci_q);

    // R6: nothing armed on a wake position means no wake next cycle
    a_r6_wake_quiet: assert property (@(posedge clk)
        disable iff (rst_any)
        ((armed & WAKE_MASK) == '0) |=> !wake_q);

endmodule

// File: rtl/gpe_evt_ctrl.sv
module gpe_evt_ctrl
    import gpe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_resume,
    input  logic        rst_rtc,
    input  logic        pbo_evt,
    input  logic        hard_rst,
    input  logic        reg_wr_en,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] evt_pulse,
    output logic        sci_o,
    output logic        wake_o
);

    gpe_sel_e sel;
    gpe_vec_t sts_q;
    gpe_vec_t en_q;
    logic     sts_wr;
    logic     en_wr;

    assign sel    = gpe_sel_e'(reg_sel);
    assign sts_wr = reg_wr_en && (sel == SEL_STS);
    assign en_wr  = reg_wr_en && (sel == SEL_EN);

    gpe_status_bank u_sts (
        .clk        (clk),
        .rst_resume (rst_resume),
        .rst_rtc    (rst_rtc),
        .clr_wr     (sts_wr),
        .clr_data   (reg_wdata),
        .pulse      (evt_pulse),
        .sts_q      (sts_q)
    );

    gpe_enable_bank u_en (
        .clk        (clk),
        .rst_resume (rst_resume),
        .rst_rtc    (rst_rtc),
        .pbo_evt    (pbo_evt),
        .hard_rst   (hard_rst),
        .en_wr      (en_wr),
        .en_data    (reg_wdata),
        .en_q       (en_q)
    );

    gpe_route u_route (
        .clk     (clk),
        .rst_any (rst_resume || rst_rtc),
        .sts_q   (sts_q),
        .en_q    (en_q),
        .sci_q   (sci_o),
        .wake_q  (wake_o)
    );

    assign reg_rdata = (sel == SEL_EN) ? en_q : sts_q;

    // R2: reserved positions read zero through the port
    a_r2_read_rsvd: assert property (@(posedge clk)
        disable iff (rst_resume || rst_rtc)
        reg_wr_en |=> ((reg_rdata & RSVD_MASK) == '0));

endmodule

// File: tb/gpe_evt_ctrl_tb_top.sv
module gpe_evt_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_resume, rst_rtc, pbo_evt, hard_rst;
    logic        reg_wr_en, reg_sel;
    logic [31:0] reg_wdata, reg_rdata, evt_pulse;
    logic        sci_o, wake_o;
    int          total = 0;
    int          bad   = 0;

    localparam logic [31:0] ALLV  = 32'hFFFF_397F;
    localparam logic [31:0] RTCB  = 32'h0000_2900;
    localparam logic [31:0] RESB  = 32'hFFFF_107F;
    localparam logic [31:0] KEEPB = 32'h0000_2100;

    always #5 clk = ~clk;

    gpe_evt_ctrl dut_i (
        .clk(clk), .rst_resume(rst_resume), .rst_rtc(rst_rtc),
        .pbo_evt(pbo_evt), .hard_rst(hard_rst),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .sci_o(sci_o), .wake_o(wake_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [31:0] d);
        evt_pulse = d;
        tick();
        evt_pulse = '0;
    endtask

    task automatic clear_all();
        wr(1'b1, '0);
        wr(1'b0, '1);
        tick();
    endtask

    task automatic fill_all();
        wr(1'b1, '1);
        pulse('1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_resume = 1'b1; rst_rtc = 1'b1;
        repeat (3) tick();
        rst_resume = 1'b0; rst_rtc = 1'b0;
        tick();
        rd(1'b0, v); chk("R1 status", v, '0);
        rd(1'b1, v); chk("R1 enable", v, '0);
        chk("R1 sci", {31'd0, sci_o}, '0);
        chk("R1 wake", {31'd0, wake_o}, '0);
    endtask

    task automatic t_rw_rsvd();
        logic [31:0] v;
        wr(1'b1, 32'h1234_5678);
        rd(1'b1, v); chk("R2 pattern", v, 32'h1234_5678 & ALLV);
        wr(1'b1, '1);
        rd(1'b1, v); chk("R2 enable rsvd", v, ALLV);
        pulse('1);
        rd(1'b0, v); chk("R2 status rsvd", v, ALLV);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pulse(32'h8001_2010);
        rd(1'b0, v); chk("R3 set", v, 32'h8001_2010);
        wr(1'b0, 32'h0000_0000);
        rd(1'b0, v); chk("R3 zero write", v, 32'h8001_2010);
        wr(1'b0, 32'h0001_0010);
        rd(1'b0, v); chk("R3 partial clear", v, 32'h8000_2000);
        wr(1'b0, '1);
        rd(1'b0, v); chk("R3 full clear", v, '0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        evt_pulse = 32'h0010_0000;
        reg_sel = 1'b0; reg_wdata = 32'h0010_0001; reg_wr_en = 1'b1;
        pulse(32'h0000_0001);
        rd(1'b0, v);
        evt_pulse = 32'h0010_0000;
        reg_sel = 1'b0; reg_wdata = 32'h0010_0001; reg_wr_en = 1'b1;
        tick();
        evt_pulse = '0; reg_wr_en = 1'b0; reg_wdata = '0;
        rd(1'b0, v); chk("R4 pulse beats clear", v, 32'h0010_0000);
        clear_all();
    endtask

    task automatic t_route(input int idx, input logic exp_sci, input logic exp_wake);
        clear_all();
        wr(1'b1, 32'd1 << idx);
        pulse(32'd1 << idx);
        chk($sformatf("R5 sci lag bit%0d", idx), {31'd0, sci_o}, '0);
        tick();
        chk($sformatf("R5 sci bit%0d", idx), {31'd0, sci_o}, {31'd0, exp_sci});
        chk($sformatf("R6 wake bit%0d", idx), {31'd0, wake_o}, {31'd0, exp_wake});
    endtask

    task automatic t_route_disabled();
        clear_all();
        pulse(32'h0000_2040);
        tick();
        chk("R5 disabled sci", {31'd0, sci_o}, '0);
        chk("R6 disabled wake", {31'd0, wake_o}, '0);
        clear_all();
    endtask

    task automatic t_pbo();
        logic [31:0] v;
        clear_all();
        fill_all();
        reg_sel = 1'b1; reg_wdata = '1; reg_wr_en = 1'b1; pbo_evt = 1'b1;
        tick();
        pbo_evt = 1'b0; reg_wr_en = 1'b0;
        rd(1'b1, v); chk("R9 pbo enable", v, KEEPB);
        rd(1'b0, v); chk("R9 pbo status", v, ALLV);
    endtask

    task automatic t_hard();
        logic [31:0] v;
        clear_all();
        fill_all();
        hard_rst = 1'b1; tick(); hard_rst = 1'b0;
        rd(1'b1, v); chk("R10 hard enable", v, RTCB);
        rd(1'b0, v); chk("R10 hard status", v, ALLV);
    endtask

    task automatic t_rst_resume();
        logic [31:0] v;
        clear_all();
        fill_all();
        rst_resume = 1'b1; tick(); rst_resume = 1'b0;
        rd(1'b1, v); chk("R7 resume enable", v, RTCB);
        rd(1'b0, v); chk("R7 resume status", v, RTCB);
    endtask

    task automatic t_rst_rtc();
        logic [31:0] v;
        clear_all();
        fill_all();
        rst_rtc = 1'b1; tick(); rst_rtc = 1'b0;
        rd(1'b1, v); chk("R8 rtc enable", v, RESB);
        rd(1'b0, v); chk("R8 rtc status", v, RESB);
    endtask

    initial begin
        rst_resume = 1'b1; rst_rtc = 1'b1; pbo_evt = 1'b0; hard_rst = 1'b0;
        reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wdata = '0; evt_pulse = '0;
        t_reset();
        t_rw_rsvd();
        t_w1c();
        t_prio();
        t_route(6,  1'b1, 1'b0);
        t_route(0,  1'b1, 1'b0);
        t_route(5,  1'b0, 1'b1);
        t_route(4,  1'b0, 1'b1);
        t_route(12, 1'b0, 1'b1);
        t_route(8,  1'b0, 1'b1);
        t_route(11, 1'b1, 1'b1);
        t_route(13, 1'b1, 1'b1);
        t_route(23, 1'b1, 1'b1);
        t_route_disabled();
        t_pbo();
        t_hard();
        t_rst_resume();
        t_rst_rtc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule